// File: doc/BRIEF.md
# Double-Width Unsigned Divider with Early Overflow Detection

This block divides a 32-bit unsigned dividend by a 16-bit unsigned divisor. The dividend arrives as two 16-bit halves. The result is a 16-bit quotient and a 16-bit remainder. A one-cycle start pulse captures all operands.

Before any arithmetic, the block compares the upper half of the dividend with the divisor. If the upper half is not strictly smaller, the quotient cannot fit in 16 bits. In that case the block reports a divide error on the next cycle and leaves the previous results in place. A zero divisor fails this same test, so division by zero needs no separate path.

When the operands pass the test, a restoring shift-subtract loop produces one quotient bit per clock. The new results are published together with a one-cycle done pulse.

Top module: `dword_divider`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `busy`, `done` and `div_err` are low, and `quot` and `rem` are zero.
- R2: For accepted operands, the dividend is `{hi_in, lo_in}`, with `hi_in` in bits 31..16. The integer quotient of that value by `dvsr_in` is presented on `quot`.
- R3: A start pulse with `hi_in >= dvsr_in` is an overflow. In the cycle after start, `done` and `div_err` are both high and `busy` stays low. For example, 0x00876002 / 0x10 is an overflow.
- R4: A zero divisor is always reported through the same `div_err`/`done` response described in R3.
- R5: On a divide error, `quot` and `rem` keep the values they held before the start pulse.
- R6: For accepted operands, `rem` shows the unsigned remainder. For example, 0x00876002 / 0x100 gives quotient 0x8760 and remainder 0x0002.
- R7: Accepted operands raise `busy` in the cycle after start. `busy` stays high for exactly 16 cycles, and `done` rises with `div_err` low on the cycle `busy` falls.
- R8: `done` is a single-cycle pulse, and `div_err` is never high without `done`.
- R9: A start pulse while `busy` is high is ignored. The running division finishes on its original schedule with its original operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division with the present operands |
| hi_in | input | 16 | Upper half of the dividend |
| lo_in | input | 16 | Lower half of the dividend |
| dvsr_in | input | 16 | Divisor |
| busy | output | 1 | Division loop running |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Overflow or zero divisor, pulsed with done |
| quot | output | 16 | Last valid quotient |
| rem | output | 16 | Last valid remainder |

## Verification
The embedded properties look at the operand inputs only in a cycle where `start` is high and the block is idle. Between such cycles, the operands may take any value.

The properties also assume `start` and the operands are stable around the rising edge. The bench meets this by changing every input on the falling edge.

The bench deliberately sends start pulses with fresh operands during a running division. It also issues a new start in the very cycle `done` is presented, which is legal because the block is idle then.

// File: rtl/dword_divider.sv
module dword_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] lo_in,
  input  logic [W-1:0] dvsr_in,
  output logic         busy,
  output logic         done,
  output logic         div_err,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  acc, qsh, dv;
  logic [CW-1:0] cnt;
  logic          run;

  wire [W:0]   shl      = {acc, qsh[W-1]};
  wire [W:0]   diff     = shl - {1'b0, dv};
  wire         take     = ~diff[W];
  wire [W-1:0] acc_nxt  = take ? diff[W-1:0] : shl[W-1:0];
  wire [W-1:0] qsh_nxt  = {qsh[W-2:0], take};
  wire         accept   = start & ~run;
  wire         fits     = hi_in < dvsr_in;

  assign busy = run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      qsh     <= '0;
      dv      <= '0;
      cnt     <= '0;
      run     <= 1'b0;
      done    <= 1'b0;
      div_err <= 1'b0;
      quot    <= '0;
      rem     <= '0;
    end else begin
      done    <= 1'b0;
      div_err <= 1'b0;
      if (accept) begin
        if (!fits) begin
          done    <= 1'b1;
          div_err <= 1'b1;
        end else begin
          run <= 1'b1;
          acc <= hi_in;
          qsh <= lo_in;
          dv  <= dvsr_in;
          cnt <= CW'(W);
        end
      end else if (run) begin
        acc <= acc_nxt;
        qsh <= qsh_nxt;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
          quot <= qsh_nxt;
          rem  <= acc_nxt;
        end
      end
    end
  end

  a_r3_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !run && hi_in >= dvsr_in) |=> (done && div_err && !run));

  a_r4_zero_div: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !run && dvsr_in == '0) |=> div_err);

  a_r5_hold_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |-> ($stable(quot) && $stable(rem)));

  a_r6_rem_below_dvsr: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_err) |-> (rem < dv));

  a_r7_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !run && hi_in < dvsr_in) |=> run);

  a_r7_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> (done && !div_err));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_err_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |-> done);

  a_r9_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt > CW'(1)) |=> (run && $stable(dv)));
endmodule

// File: tb/sim_dword_divider.sv
`timescale 1ns/1ps
module sim_dword_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] hi_in = '0, lo_in = '0, dvsr_in = '0;
  logic        busy, done, div_err;
  logic [15:0] quot, rem;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dword_divider #(.W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .hi_in(hi_in), .lo_in(lo_in),
    .dvsr_in(dvsr_in), .busy(busy), .done(done), .div_err(div_err),
    .quot(quot), .rem(rem)
  );

  // behavioural reference
  bit          m_busy, m_done, m_err;
  int          m_cnt;
  logic [15:0] m_quot, m_rem, p_quot, p_rem;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_cnt = 0;
      m_quot = '0; m_rem = '0; p_quot = '0; p_rem = '0;
    end else begin
      logic [31:0] dd;
      m_done = 0;
      m_err  = 0;
      if (m_busy) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_quot = p_quot; m_rem = p_rem;
        end
      end else if (start) begin
        if (dvsr_in == 0 || hi_in >= dvsr_in) begin
          m_done = 1; m_err = 1;
        end else begin
          dd = {hi_in, lo_in};
          p_quot = 16'(dd / {16'h0, dvsr_in});
          p_rem  = 16'(dd % {16'h0, dvsr_in});
          m_busy = 1; m_cnt = 16;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      vectors++;
      if (busy !== m_busy) begin
        fails++; $display("FAIL R7/R9 busy got %b exp %b at %0t", busy, m_busy, $time);
      end
      if (done !== m_done) begin
        fails++; $display("FAIL R8 done got %b exp %b at %0t", done, m_done, $time);
      end
      if (div_err !== m_err) begin
        fails++; $display("FAIL R3/R4 div_err got %b exp %b at %0t", div_err, m_err, $time);
      end
      if (quot !== m_quot) begin
        fails++; $display("FAIL R2/R5 quot got %h exp %h at %0t", quot, m_quot, $time);
      end
      if (rem !== m_rem) begin
        fails++; $display("FAIL R6/R5 rem got %h exp %h at %0t", rem, m_rem, $time);
      end
    end
  end

  task automatic pulse(input logic [15:0] h, input logic [15:0] l, input logic [15:0] d);
    @(negedge clk);
    start = 1'b1; hi_in = h; lo_in = l; dvsr_in = d;
    @(negedge clk);
    start = 1'b0; hi_in = $urandom; lo_in = $urandom; dvsr_in = $urandom;
  endtask

  task automatic run_one(input logic [15:0] h, input logic [15:0] l, input logic [15:0] d);
    pulse(h, l, d);
    repeat (18) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    vectors++;
    if (busy !== 0 || done !== 0 || div_err !== 0 || quot !== 0 || rem !== 0) begin
      fails++; $display("FAIL R1 reset outputs got %b%b%b %h %h exp 000 0000 0000",
                        busy, done, div_err, quot, rem);
    end
    rst_n = 1'b1;
    @(negedge clk);
    run_one(16'h0087, 16'h6000, 16'h0100);   // R2 valid: 0x8760 r 0
    run_one(16'h0087, 16'h6002, 16'h0010);   // R3 overflow, R5 hold
    run_one(16'h0087, 16'h6002, 16'h0100);   // R6 remainder 2
    run_one(16'h1234, 16'h5678, 16'h0000);   // R4 divide by zero
    run_one(16'h0100, 16'h0000, 16'h0100);   // R3 boundary hi == divisor
    run_one(16'hFFFE, 16'hFFFF, 16'hFFFF);   // R2 largest quotient
    run_one(16'h0000, 16'h0000, 16'h0005);   // R2 zero dividend
    run_one(16'h0000, 16'hFFFF, 16'h0001);   // R2 divide by one
    // R9: start pulses while busy
    pulse(16'h0003, 16'h1111, 16'h0007);
    repeat (4) @(negedge clk);
    pulse(16'h0000, 16'h0001, 16'h0002);
    pulse(16'hFFFF, 16'hFFFF, 16'h0001);
    repeat (16) @(negedge clk);
    // back-to-back: start on the done cycle
    pulse(16'h0001, 16'h2345, 16'h0010);
    repeat (15) @(negedge clk);
    pulse(16'h0002, 16'h0000, 16'h0003);
    repeat (18) @(negedge clk);
    for (int i = 0; i < 60; i++) begin
      logic [15:0] d, h;
      d = 16'($urandom);
      if (d == 0) d = 16'h1;
      h = (i % 5 == 0) ? 16'($urandom) : 16'($urandom % d);
      run_one(h, 16'($urandom), d);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule